// File: doc/BRIEF.md
# L1 Sharer Presence Directory

This block sits beside a shared second-level cache and keeps, for every second-level line, a bit vector telling which of the per-core first-level data caches currently hold a copy. The first-level caches write through and never allocate on a store, so the directory stores presence bits only. It has no owner or dirty state. Coherence needs nothing but invalidations, and line data is always supplied by the second-level cache.

Each cycle the block accepts at most one request: a core number, a line index and an operation. Loads mark the requester as a sharer and return a fill grant. Stores invalidate every other sharer and leave the entry empty. A first-level eviction notice drops one sharer silently. A second-level eviction invalidates every sharer, which keeps the first-level caches a subset of the second level. Results are registered and appear one cycle after the request.

Top module: `l1_sharer_dir`

## Requirements
- R1: While reset is low, and after reset until the first request, `inv_valid`, `inv_vec`, `grant_valid` and `grant_core` are zero. Reset empties every entry, so a second-level eviction issued after reset produces no invalidation.
- R2: A load (`req_op` = 0) adds the requesting core to the line's entry. One cycle later it raises `grant_valid` with `grant_core` equal to the requester, and it raises no invalidation.
- R3: A store (`req_op` = 1) puts out, one cycle later, `inv_vec` equal to the entry's presence bits with the storing core's bit cleared. `inv_valid` is raised in that cycle only if this vector is non-zero.
- R4: After a store the line's entry is all zeros, and this includes the storing core's bit.
- R5: A store never adds the storing core to the entry, so a second store by the same core to the same line produces no invalidation.
- R6: A first-level eviction notice (`req_op` = 2) removes only the requesting core from the entry. It produces no invalidation and no grant.
- R7: A second-level eviction (`req_op` = 3) puts out the full presence vector as `inv_vec` one cycle later, with `inv_valid` set when that vector is non-zero, and then leaves the entry all zeros.
- R8: Entries are independent: a request changes only the entry selected by `req_line`, and every index from 0 to NLINES-1 can be used.
- R9: A new request can be accepted every cycle. A request to the same line in the very next cycle sees the entry as updated by the previous request.
- R10: While `req_valid` is low, the outputs in the following cycle are zero and no entry changes, whatever values are on the other request inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_core | input | $clog2(NCORES) | Requesting core number |
| req_line | input | $clog2(NLINES) | Second-level line index |
| req_op | input | 2 | 0 load, 1 store, 2 first-level eviction, 3 second-level eviction |
| inv_valid | output | 1 | Invalidation vector is valid this cycle |
| inv_vec | output | NCORES | One bit per core to invalidate |
| grant_valid | output | 1 | Fill grant for the load of the previous cycle |
| grant_core | output | $clog2(NCORES) | Core receiving the fill grant |

## Verification
The assertions assume that `req_valid` stays low while reset is held. They also assume that `req_line` is below NLINES and `req_core` is below NCORES, which the default power-of-two sizes guarantee. The bench drives requests only after reset is released and uses indices inside these ranges, including the top line 63 and core 7. Since the presence bits are internal, they are observed through the ports: a second-level eviction shows the entry's full contents as an invalidation vector.

// File: rtl/l1_sharer_dir.sv
module l1_sharer_dir #(
  parameter int NCORES = 8,
  parameter int NLINES = 64,
  localparam int CW = $clog2(NCORES),
  localparam int LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CW-1:0]     req_core,
  input  logic [LW-1:0]     req_line,
  input  logic [1:0]        req_op,
  output logic              inv_valid,
  output logic [NCORES-1:0] inv_vec,
  output logic              grant_valid,
  output logic [CW-1:0]     grant_core
);

  localparam logic [1:0] OP_LOAD    = 2'd0;
  localparam logic [1:0] OP_STORE   = 2'd1;
  localparam logic [1:0] OP_DROP    = 2'd2;
  localparam logic [1:0] OP_RECLAIM = 2'd3;

  logic [NCORES-1:0] pres [NLINES];
  logic [NCORES-1:0] cur, self, nxt, inv;

  assign cur  = pres[req_line];
  assign self = {{(NCORES-1){1'b0}}, 1'b1} << req_core;

  always_comb begin
    nxt = cur;
    inv = '0;
    case (req_op)
      OP_LOAD:    nxt = cur | self;
      OP_STORE:   begin inv = cur & ~self; nxt = '0; end
      OP_DROP:    nxt = cur & ~self;
      OP_RECLAIM: begin inv = cur; nxt = '0; end
      default:    nxt = cur;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) pres[i] <= '0;
      inv_valid   <= 1'b0;
      inv_vec     <= '0;
      grant_valid <= 1'b0;
      grant_core  <= '0;
    end else begin
      inv_valid   <= req_valid && (|inv);
      inv_vec     <= req_valid ? inv : '0;
      grant_valid <= req_valid && (req_op == OP_LOAD);
      grant_core  <= req_valid ? req_core : '0;
      if (req_valid) pres[req_line] <= nxt;
    end
  end

endmodule

// File: rtl/l1_sharer_dir_chk.sv
module l1_sharer_dir_chk #(
  parameter int NCORES = 8,
  parameter int CW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [CW-1:0]     req_core,
  input logic [1:0]        req_op,
  input logic              inv_valid,
  input logic [NCORES-1:0] inv_vec,
  input logic              grant_valid,
  input logic [CW-1:0]     grant_core
);

  a_r2_load_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid) && $past(req_op) == 2'd0)
      |-> (grant_valid && grant_core == $past(req_core) && !inv_valid));

  a_r3_store_spares_self: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid) && $past(req_op) == 2'd1 && inv_valid)
      |-> !inv_vec[$past(req_core)]);

  a_r3_strobe_needs_bits: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (inv_vec != '0));

  a_r6_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid) && $past(req_op) == 2'd2)
      |-> (!inv_valid && !grant_valid));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(req_valid))
      |-> (!inv_valid && !grant_valid && inv_vec == '0));

  a_r7_grant_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_valid && inv_valid));

endmodule

bind l1_sharer_dir l1_sharer_dir_chk #(.NCORES(NCORES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
  .req_op(req_op), .inv_valid(inv_valid), .inv_vec(inv_vec),
  .grant_valid(grant_valid), .grant_core(grant_core)
);

// File: tb/l1_sharer_dir_bench.sv
module l1_sharer_dir_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       req_valid = 0;
  logic [2:0] req_core = 0;
  logic [5:0] req_line = 0;
  logic [1:0] req_op = 0;
  logic       inv_valid, grant_valid;
  logic [7:0] inv_vec;
  logic [2:0] grant_core;

  int total = 0;
  int bad = 0;
  logic       o_iv, o_gv;
  logic [7:0] o_vec;
  logic [2:0] o_gc;

  always #10 clk = ~clk;

  l1_sharer_dir u_l1_sharer_dir (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
    .req_line(req_line), .req_op(req_op), .inv_valid(inv_valid),
    .inv_vec(inv_vec), .grant_valid(grant_valid), .grant_core(grant_core)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic v, input int core, input int line, input int op);
    @(negedge clk);
    req_valid = v; req_core = core[2:0]; req_line = line[5:0]; req_op = op[1:0];
    @(posedge clk);
    #2;
    o_iv = inv_valid; o_vec = inv_vec; o_gv = grant_valid; o_gc = grant_core;
    req_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 inv_valid in reset", inv_valid, 0);
    chk("R1 grant_valid in reset", grant_valid, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 inv_vec after reset", inv_vec, 0);
    issue(1, 0, 5, 3);
    chk("R1 empty entry no strobe", o_iv, 0);
    chk("R1 empty entry vector", o_vec, 0);
  endtask

  task automatic t_load_share;
    issue(1, 0, 3, 0);
    chk("R2 grant core0", o_gv, 1); chk("R2 grant id core0", o_gc, 0);
    chk("R2 no inv on load", o_iv, 0);
    issue(1, 2, 3, 0);
    chk("R2 grant id core2", o_gc, 2);
    issue(1, 7, 3, 0);
    chk("R2 grant id core7", o_gc, 7);
    issue(1, 1, 3, 3);
    chk("R7 reclaim strobe", o_iv, 1); chk("R7 reclaim vector", o_vec, 8'h85);
    issue(1, 1, 3, 3);
    chk("R7 entry cleared", o_iv, 0);
  endtask

  task automatic t_store;
    issue(1, 1, 10, 0); issue(1, 4, 10, 0); issue(1, 6, 10, 0);
    issue(1, 4, 10, 1);
    chk("R3 store strobe", o_iv, 1); chk("R3 store vector", o_vec, 8'h42);
    chk("R3 store no grant", o_gv, 0);
    issue(1, 0, 10, 3);
    chk("R4 entry empty after store", o_iv, 0);
  endtask

  task automatic t_store_outsider;
    issue(1, 2, 11, 0);
    issue(1, 5, 11, 1);
    chk("R3 outsider store vector", o_vec, 8'h04); chk("R3 outsider strobe", o_iv, 1);
    issue(1, 5, 11, 1);
    chk("R5 second store silent", o_iv, 0);
    issue(1, 5, 11, 3);
    chk("R5 storer not added", o_vec, 0);
  endtask

  task automatic t_drop;
    issue(1, 0, 20, 0); issue(1, 3, 20, 0);
    issue(1, 3, 20, 2);
    chk("R6 drop no inv", o_iv, 0); chk("R6 drop no grant", o_gv, 0);
    issue(1, 2, 20, 3);
    chk("R6 only requester removed", o_vec, 8'h01);
  endtask

  task automatic t_lines;
    issue(1, 1, 30, 0); issue(1, 6, 31, 0); issue(1, 7, 63, 0);
    issue(1, 0, 30, 3);
    chk("R8 line30", o_vec, 8'h02);
    issue(1, 0, 31, 3);
    chk("R8 line31", o_vec, 8'h40);
    issue(1, 0, 63, 3);
    chk("R8 top line", o_vec, 8'h80);
  endtask

  task automatic t_idle;
    issue(1, 5, 40, 0);
    issue(0, 5, 40, 3);
    chk("R10 idle no strobe", o_iv, 0); chk("R10 idle vector", o_vec, 0);
    chk("R10 idle no grant", o_gv, 0);
    issue(0, 5, 40, 1);
    issue(1, 0, 40, 3);
    chk("R10 entry untouched", o_vec, 8'h20);
  endtask

  task automatic t_back2back;
    issue(1, 2, 50, 0);
    issue(1, 3, 50, 1);
    chk("R9 store sees prior load", o_vec, 8'h04);
    issue(1, 3, 50, 0);
    issue(1, 3, 50, 2);
    issue(1, 3, 50, 3);
    chk("R9 load then drop", o_iv, 0);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_load_share();
    t_store();
    t_store_outsider();
    t_drop();
    t_lines();
    t_idle();
    t_back2back();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule